// File: doc/BRIEF.md
# Received Frame Priority Queue Screener

This block assigns every received Ethernet frame to one of six priority queues. It watches the receive byte stream one byte per cycle. From that stream it picks out the EtherType, the IPv4 differentiated-services byte or the IPv6 traffic-class byte, the IP protocol or next-header value, and the UDP destination port. At the last byte of the frame it compares these fields against four programmable screening entries.

Software programs the entries through a small word-addressed register port. Each entry can compare the class byte, the UDP destination port, or both. Each entry names the queue to use when it matches. The frame's queue number is presented, with a valid strobe, in the same cycle as the end-of-frame byte.

Top module: `rx_prio_screener`

## Requirements
- R1: After a synchronous reset, all four screening entries read as zero and `q_valid` is low.
- R2: Entry x (x = 0..3) sits at byte address 0x500 + 4x. Its bit fields are:
  - bit 29: UDP port compare enable
  - bit 28: class compare enable
  - bits 27:12: port value
  - bits 11:4: class value
  - bits 2:0: queue

  Bits 31:30 and bit 3 always read 0. A read of any other address returns 0. A write to any other address, including a misaligned one, changes nothing.
- R3: Bytes 12-13 of the frame are the EtherType, big-endian. The IP header starts at byte 14. When the EtherType is 0x0800, the class byte is frame byte 15.
- R4: When the EtherType is 0x86DD, the class byte is formed from byte 14 bits 3:0 (as class bits 7:4) and byte 15 bits 7:4 (as class bits 3:0).
- R5: A frame counts as UDP when the protocol field equals 17. For IPv4 this field is frame byte 23; for IPv6 it is frame byte 20. The destination port is big-endian. For IPv4 it starts at IP offset IHL*4+2, where IHL is the low nibble of byte 14. For IPv6 it starts at IP offset 42.
- R6: A frame that is not UDP, or an IPv4 frame with IHL below 5, fails every entry whose port compare is enabled.
- R7: An entry matches only when at least one compare is enabled and every enabled compare is equal. With both compares enabled, both must be equal. With both disabled, the entry never matches.
- R8: When several entries match, the lowest-numbered one wins. When none match, the queue is 0.
- R9: A matching entry whose queue field is 6 or 7 gives queue 0.
- R10: `q_valid` is high only in a cycle with `rx_valid` and `rx_eof` both high. `q_num` is valid in that same cycle. Frames that are too short or are not IP still get the strobe, with queue 0.
- R11: A byte with `rx_sof` set is byte 0 of a new frame. It discards any fields collected from an unfinished earlier frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 12 | Register byte address |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_addr) |
| rx_valid | input | 1 | Receive byte valid |
| rx_sof | input | 1 | First byte of frame |
| rx_eof | input | 1 | Last byte of frame |
| rx_data | input | 8 | Receive byte |
| q_valid | output | 1 | Queue decision strobe |
| q_num | output | 3 | Queue number (0 when q_valid is low) |

## Verification
The assertions assume that `rx_sof` and `rx_eof` are only considered while `rx_valid` is high. They also assume that a frame's fields arrive in wire order, one byte per valid cycle, and that register writes do not collide with the end-of-frame byte in a way that matters. The stimulus drives complete frames built byte by byte in network order, plus one frame cut short before its end. Register writes happen only between frames. All inputs change on the falling edge.

// File: rtl/rxscr_pkg.sv
package rxscr_pkg;

    localparam int NUM_Q = 6;
    localparam int Q_W   = 3;

    localparam logic [31:0] ENT_MASK = 32'h3FFF_FFF7;

    localparam logic [15:0] ETYPE_V4  = 16'h0800;
    localparam logic [15:0] ETYPE_V6  = 16'h86DD;
    localparam logic [7:0]  PROTO_UDP = 8'd17;

    localparam int L2_HDR     = 14;
    localparam int V4_PROTO   = 9;
    localparam int V6_NH      = 6;
    localparam int V6_HDR     = 40;
    localparam int DPORT_OFS  = 2;
    localparam int V4_MIN_IHL = 5;

    typedef struct packed {
        logic           udp_en;
        logic           cls_en;
        logic [15:0]    port;
        logic [7:0]     cls;
        logic [Q_W-1:0] qnum;
    } scr_ent_t;

    typedef enum logic [1:0] {
        IPK_NONE = 2'd0,
        IPK_V4   = 2'd1,
        IPK_V6   = 2'd2
    } ip_kind_e;

    typedef struct packed {
        logic [7:0]  etype_hi;
        ip_kind_e    kind;
        logic [3:0]  ihl;
        logic [7:0]  cls;
        logic        cls_ok;
        logic        is_udp;
        logic [15:0] port;
        logic        port_ok;
    } hdr_st_t;

    typedef struct packed {
        logic [7:0]  cls;
        logic        cls_ok;
        logic        is_udp;
        logic [15:0] port;
        logic        port_ok;
    } fld_t;

    function automatic scr_ent_t word_to_ent(logic [31:0] w);
        scr_ent_t e;
        e.udp_en = w[29];
        e.cls_en = w[28];
        e.port   = w[27:12];
        e.cls    = w[11:4];
        e.qnum   = w[2:0];
        return e;
    endfunction

    function automatic logic [Q_W-1:0] clamp_q(logic [Q_W-1:0] q);
        return (int'(q) < NUM_Q) ? q : '0;
    endfunction

endpackage

// File: rtl/scr_regfile.sv
module scr_regfile
    import rxscr_pkg::*;
#(
    parameter int               N_ENT  = 4,
    parameter int               ADDR_W = 12,
    parameter logic [ADDR_W-1:0] BASE  = 12'h500
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [ADDR_W-1:0]     reg_addr,
    input  logic                  reg_we,
    input  logic [31:0]           reg_wdata,
    output logic [31:0]           reg_rdata,
    output scr_ent_t [N_ENT-1:0]  ent_o
);
    localparam int               IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1;
    localparam logic [ADDR_W-1:0] SPAN = ADDR_W'(4 * N_ENT);

    logic [31:0]       ent_q [N_ENT];
    logic [ADDR_W-1:0] off;
    logic              hit;
    logic [IDX_W-1:0]  idx;

    always_comb begin
        off = reg_addr - BASE;
        hit = (reg_addr >= BASE) && (off < SPAN) && (off[1:0] == 2'b00);
        idx = off[IDX_W+1:2];
        reg_rdata = hit ? ent_q[idx] : 32'h0;
    end

    for (genvar i = 0; i < N_ENT; i++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst) begin
                ent_q[i] <= '0;
            end else if (reg_we && hit && (idx == IDX_W'(i))) begin
                ent_q[i] <= reg_wdata & ENT_MASK;
            end
        end

        assign ent_o[i] = word_to_ent(ent_q[i]);

        // R2
        wr_capture_chk: assert property (@(posedge clk) disable iff (rst)
            (reg_we && hit && (idx == IDX_W'(i))) |=> (ent_q[i] == ($past(reg_wdata) & ENT_MASK)));
    end

    // R2
    rsv_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_rdata & ~ENT_MASK) == 32'h0);

endmodule

// File: rtl/scr_hdr_extract.sv
module scr_hdr_extract
    import rxscr_pkg::*;
#(
    parameter int CNT_W = 11
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       rx_valid,
    input  logic       rx_sof,
    input  logic [7:0] rx_data,
    output fld_t       fld_o
);
    localparam logic [CNT_W-1:0] ONE       = CNT_W'(1);
    localparam logic [CNT_W-1:0] CNT_MAX   = '1;
    localparam logic [CNT_W-1:0] P_ET_HI   = CNT_W'(L2_HDR - 2);
    localparam logic [CNT_W-1:0] P_ET_LO   = CNT_W'(L2_HDR - 1);
    localparam logic [CNT_W-1:0] P_IP0     = CNT_W'(L2_HDR);
    localparam logic [CNT_W-1:0] P_IP1     = CNT_W'(L2_HDR + 1);
    localparam logic [CNT_W-1:0] P_V4_PR   = CNT_W'(L2_HDR + V4_PROTO);
    localparam logic [CNT_W-1:0] P_V6_NH   = CNT_W'(L2_HDR + V6_NH);
    localparam logic [CNT_W-1:0] P_V6_PORT = CNT_W'(L2_HDR + V6_HDR + DPORT_OFS);
    localparam logic [CNT_W-1:0] P_V4_PB   = CNT_W'(L2_HDR + DPORT_OFS);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] idx;
    logic [CNT_W-1:0] po;
    hdr_st_t          st_q;
    hdr_st_t          base;
    hdr_st_t          nxt;

    always_comb begin
        base = rx_sof ? '0 : st_q;
        idx  = rx_sof ? '0 : cnt_q;
        po   = (base.kind == IPK_V6) ? P_V6_PORT
                                     : P_V4_PB + CNT_W'({base.ihl, 2'b00});
        nxt  = base;

        if (idx == P_ET_HI) begin
            nxt.etype_hi = rx_data;
        end
        if (idx == P_ET_LO) begin
            if ({base.etype_hi, rx_data} == ETYPE_V4)      nxt.kind = IPK_V4;
            else if ({base.etype_hi, rx_data} == ETYPE_V6) nxt.kind = IPK_V6;
            else                                           nxt.kind = IPK_NONE;
        end
        if (idx == P_IP0) begin
            if (base.kind == IPK_V4) nxt.ihl = rx_data[3:0];
            if (base.kind == IPK_V6) nxt.cls[7:4] = rx_data[3:0];
        end
        if (idx == P_IP1) begin
            if (base.kind == IPK_V4) begin
                nxt.cls    = rx_data;
                nxt.cls_ok = 1'b1;
            end
            if (base.kind == IPK_V6) begin
                nxt.cls[3:0] = rx_data[7:4];
                nxt.cls_ok   = 1'b1;
            end
        end
        if ((base.kind == IPK_V4) && (idx == P_V4_PR)) begin
            nxt.is_udp = (rx_data == PROTO_UDP) && (int'(base.ihl) >= V4_MIN_IHL);
        end
        if ((base.kind == IPK_V6) && (idx == P_V6_NH)) begin
            nxt.is_udp = (rx_data == PROTO_UDP);
        end
        if ((base.kind != IPK_NONE) && (idx == po)) begin
            nxt.port[15:8] = rx_data;
        end
        if ((base.kind != IPK_NONE) && (idx == po + ONE)) begin
            nxt.port[7:0] = rx_data;
            nxt.port_ok   = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            st_q  <= '0;
        end else if (rx_valid) begin
            st_q  <= nxt;
            cnt_q <= (idx == CNT_MAX) ? idx : idx + ONE;
        end
    end

    assign fld_o = '{cls:     nxt.cls,
                     cls_ok:  nxt.cls_ok,
                     is_udp:  nxt.is_udp,
                     port:    nxt.port,
                     port_ok: nxt.port_ok};

    // R11
    sof_restart_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && rx_sof) |=> (cnt_q == ONE));

    // R3
    cls_needs_ip_chk: assert property (@(posedge clk) disable iff (rst)
        st_q.cls_ok |-> (st_q.kind != IPK_NONE));

endmodule

// File: rtl/scr_match.sv
module scr_match
    import rxscr_pkg::*;
#(
    parameter int N_ENT = 4
) (
    input  scr_ent_t [N_ENT-1:0] ent_i,
    input  fld_t                 fld_i,
    output logic [Q_W-1:0]       q_o
);
    logic [N_ENT-1:0] hit;
    logic [N_ENT-1:0] win;
    logic [Q_W-1:0]   sel;

    for (genvar i = 0; i < N_ENT; i++) begin : g_cmp
        logic udp_eq;
        logic cls_eq;
        assign udp_eq = fld_i.is_udp && fld_i.port_ok && (fld_i.port == ent_i[i].port);
        assign cls_eq = fld_i.cls_ok && (fld_i.cls == ent_i[i].cls);
        assign hit[i] = (ent_i[i].udp_en || ent_i[i].cls_en)
                     && (!ent_i[i].udp_en || udp_eq)
                     && (!ent_i[i].cls_en || cls_eq);

        // R7
        always_comb begin
            no_enable_no_hit_chk: assert (ent_i[i].udp_en || ent_i[i].cls_en || !hit[i]);
        end
    end

    always_comb begin
        win = '0;
        sel = '0;
        for (int i = 0; i < N_ENT; i++) begin
            if (hit[i] && (win == '0)) begin
                win[i] = 1'b1;
                sel    = ent_i[i].qnum;
            end
        end
        q_o = clamp_q(sel);
    end

    // R8
    always_comb begin
        win_onehot_chk: assert ($onehot0(win));
        win_in_hit_chk: assert ((win & ~hit) == '0);
    end

endmodule

// File: rtl/rx_prio_screener.sv
module rx_prio_screener
    import rxscr_pkg::*;
#(
    parameter int N_ENT  = 4,
    parameter int ADDR_W = 12,
    parameter int CNT_W  = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_we,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              rx_valid,
    input  logic              rx_sof,
    input  logic              rx_eof,
    input  logic [7:0]        rx_data,
    output logic              q_valid,
    output logic [Q_W-1:0]    q_num
);
    scr_ent_t [N_ENT-1:0] ents;
    fld_t                 fld;
    logic [Q_W-1:0]       q_sel;

    scr_regfile #(.N_ENT(N_ENT), .ADDR_W(ADDR_W), .BASE(ADDR_W'(12'h500))) u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_addr  (reg_addr),
        .reg_we    (reg_we),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .ent_o     (ents)
    );

    scr_hdr_extract #(.CNT_W(CNT_W)) u_ext (
        .clk      (clk),
        .rst      (rst),
        .rx_valid (rx_valid),
        .rx_sof   (rx_sof),
        .rx_data  (rx_data),
        .fld_o    (fld)
    );

    scr_match #(.N_ENT(N_ENT)) u_match (
        .ent_i (ents),
        .fld_i (fld),
        .q_o   (q_sel)
    );

    assign q_valid = rx_valid && rx_eof;
    assign q_num   = q_valid ? q_sel : '0;

    // R9
    q_range_chk: assert property (@(posedge clk) disable iff (rst)
        q_valid |-> (int'(q_num) < NUM_Q));

    // R10
    q_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        q_valid |-> (rx_valid && rx_eof));

endmodule

// File: tb/rx_prio_screener_bench.sv
module rx_prio_screener_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic [11:0] reg_addr;
    logic        reg_we;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        rx_valid, rx_sof, rx_eof;
    logic [7:0]  rx_data;
    logic        q_valid;
    logic [2:0]  q_num;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    logic [7:0] frm [0:127];
    int flen;

    always #10 clk = ~clk;

    rx_prio_screener u_rx_prio_screener (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rx_valid(rx_valid),
        .rx_sof(rx_sof), .rx_eof(rx_eof), .rx_data(rx_data),
        .q_valid(q_valid), .q_num(q_num)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(bit ue, bit ce, logic [15:0] port, logic [7:0] cls, logic [2:0] q);
        return {2'b00, ue, ce, port, cls, 1'b0, q};
    endfunction

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_chk(input logic [11:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        reg_addr = a;
        #5;
        check(reg_rdata === exp, tag, reg_rdata, exp);
    endtask

    task automatic clear_all();
        for (int i = 0; i < 4; i++) wr(12'h500 + 12'(4 * i), 32'h0);
    endtask

    function automatic void fill(int n);
        for (int i = 0; i < 128; i++) frm[i] = 8'(i * 7 + 3);
        flen = n;
    endfunction

    function automatic void build_v4(logic [7:0] ds, logic [7:0] proto, logic [3:0] ihl, logic [15:0] dport);
        int off;
        fill(0);
        frm[12] = 8'h08; frm[13] = 8'h00;
        frm[14] = {4'h4, ihl}; frm[15] = ds; frm[23] = proto;
        off = 14 + int'(ihl) * 4;
        frm[off] = 8'h12; frm[off+1] = 8'h34;
        frm[off+2] = dport[15:8]; frm[off+3] = dport[7:0];
        flen = off + 12;
    endfunction

    function automatic void build_v6(logic [7:0] tc, logic [7:0] nh, logic [15:0] dport);
        fill(70);
        frm[12] = 8'h86; frm[13] = 8'hDD;
        frm[14] = {4'h6, tc[7:4]}; frm[15] = {tc[3:0], 4'h0}; frm[20] = nh;
        frm[54] = 8'h12; frm[55] = 8'h34;
        frm[56] = dport[15:8]; frm[57] = dport[7:0];
    endfunction

    task automatic send(input logic [2:0] exp_q, input bit with_eof, input string tag);
        int stray;
        stray = 0;
        for (int i = 0; i < flen; i++) begin
            @(negedge clk);
            rx_valid = 1'b1; rx_sof = (i == 0); rx_data = frm[i];
            rx_eof = with_eof && (i == flen - 1);
            #5;
            if (rx_eof) begin
                check(q_valid === 1'b1, {tag, " R10 strobe"}, q_valid, 1);
                check(q_num === exp_q, tag, q_num, exp_q);
            end else if (q_valid !== 1'b0) begin
                stray++;
            end
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0;
        #5;
        if (q_valid !== 1'b0) stray++;
        check(stray == 0, {tag, " R10 stray strobe"}, stray, 0);
    endtask

    task automatic t_reset();
        check(q_valid === 1'b0, "R1 q_valid after reset", q_valid, 0);
        for (int i = 0; i < 4; i++) rd_chk(12'h500 + 12'(4 * i), 32'h0, "R1 entry reset");
    endtask

    task automatic t_map();
        wr(12'h504, 32'hFFFF_FFFF);
        rd_chk(12'h504, 32'h3FFF_FFF7, "R2 writable mask");
        wr(12'h510, 32'hFFFF_FFFF);
        rd_chk(12'h510, 32'h0, "R2 unmapped read");
        wr(12'h502, 32'hFFFF_FFFF);
        rd_chk(12'h500, 32'h0, "R2 misaligned write ignored");
        rd_chk(12'h50C, 32'h0, "R2 neighbour untouched");
        clear_all();
    endtask

    task automatic t_v4_ds();
        wr(12'h500, mk(0, 1, 16'h0, 8'hB8, 3'd3));
        build_v4(8'hB8, 8'd17, 4'd5, 16'd0); send(3'd3, 1, "R3 v4 DS match");
        build_v4(8'h2E, 8'd17, 4'd5, 16'd0); send(3'd0, 1, "R3 v4 DS miss");
        clear_all();
    endtask

    task automatic t_v6_tc();
        wr(12'h500, mk(0, 1, 16'h0, 8'hA5, 3'd4));
        build_v6(8'hA5, 8'd17, 16'd0); send(3'd4, 1, "R4 v6 TC match");
        build_v6(8'h5A, 8'd17, 16'd0); send(3'd0, 1, "R4 v6 TC miss");
        clear_all();
    endtask

    task automatic t_udp();
        wr(12'h504, mk(1, 0, 16'd5000, 8'h0, 3'd2));
        build_v4(8'h00, 8'd17, 4'd5, 16'd5000); send(3'd2, 1, "R5 v4 port ihl5");
        build_v4(8'h00, 8'd17, 4'd6, 16'd5000); send(3'd2, 1, "R5 v4 port ihl6");
        build_v6(8'h00, 8'd17, 16'd5000);       send(3'd2, 1, "R5 v6 port");
        build_v4(8'h00, 8'd17, 4'd5, 16'd5001); send(3'd0, 1, "R5 port miss");
        build_v4(8'h00, 8'd6, 4'd5, 16'd5000);  send(3'd0, 1, "R6 non-UDP");
        build_v6(8'h00, 8'd6, 16'd5000);        send(3'd0, 1, "R6 v6 non-UDP");
        build_v4(8'h00, 8'd17, 4'd4, 16'd5000); send(3'd0, 1, "R6 ihl below 5");
        clear_all();
    endtask

    task automatic t_both();
        wr(12'h504, mk(1, 1, 16'd53, 8'h20, 3'd5));
        build_v4(8'h20, 8'd17, 4'd5, 16'd53); send(3'd5, 1, "R7 both equal");
        build_v4(8'h20, 8'd17, 4'd5, 16'd54); send(3'd0, 1, "R7 port differs");
        build_v4(8'h21, 8'd17, 4'd5, 16'd53); send(3'd0, 1, "R7 class differs");
        wr(12'h504, mk(0, 0, 16'd0, 8'h00, 3'd4));
        build_v4(8'h00, 8'd17, 4'd5, 16'd0); send(3'd0, 1, "R7 no enables");
        clear_all();
    endtask

    task automatic t_prio();
        wr(12'h500, mk(0, 1, 16'd0, 8'h10, 3'd1));
        wr(12'h508, mk(0, 1, 16'd0, 8'h10, 3'd2));
        wr(12'h50C, mk(1, 0, 16'd80, 8'h00, 3'd3));
        build_v4(8'h10, 8'd17, 4'd5, 16'd80); send(3'd1, 1, "R8 lowest wins");
        wr(12'h500, 32'h0);
        send(3'd2, 1, "R8 next lowest wins");
        wr(12'h508, 32'h0);
        send(3'd3, 1, "R8 last entry");
        clear_all();
        send(3'd0, 1, "R8 no match default");
    endtask

    task automatic t_qclamp();
        wr(12'h50C, mk(0, 1, 16'd0, 8'h44, 3'd6));
        build_v4(8'h44, 8'd17, 4'd5, 16'd0); send(3'd0, 1, "R9 queue 6");
        wr(12'h50C, mk(0, 1, 16'd0, 8'h44, 3'd7));
        send(3'd0, 1, "R9 queue 7");
        clear_all();
    endtask

    task automatic t_nonip();
        wr(12'h500, mk(0, 1, 16'd0, 8'h00, 3'd3));
        build_v4(8'h00, 8'd17, 4'd5, 16'd0); send(3'd3, 1, "R3 class zero v4");
        fill(64); frm[12] = 8'h08; frm[13] = 8'h06; frm[15] = 8'h00;
        send(3'd0, 1, "R10 non-IP default");
        fill(8); send(3'd0, 1, "R10 runt default");
        clear_all();
    endtask

    task automatic t_restart();
        wr(12'h500, mk(0, 1, 16'd0, 8'hB8, 3'd3));
        build_v4(8'hB8, 8'd17, 4'd5, 16'd0); flen = 16;
        send(3'd0, 0, "R11 partial frame");
        fill(10); send(3'd0, 1, "R11 restart clears state");
        clear_all();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; reg_addr = '0; reg_we = 1'b0; reg_wdata = '0;
        rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; rx_data = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_map();
        t_v4_ds();
        t_v6_tc();
        t_udp();
        t_both();
        t_prio();
        t_qclamp();
        t_nonip();
        t_restart();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule